// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block draws a 32x32 cursor on top of the pixel stream of one display head. Each pixel of the stream arrives with its raster coordinates and a display-enable flag; one clock later the block hands out the same pixel, either unchanged or replaced by the cursor image where the cursor covers it. The image lives in a small internal RAM of 16-bit entries that the host fills through a write port. An entry either passes the background through, paints a fixed 15-bit colour, or inverts the background.

The host sets the cursor's top-left corner through a packed position word and turns it on and off through a control word. When the control word selects retrace sync, the new position and visibility stay pending and are moved into the active registers only in cycles where vertical blanking is asserted, so the cursor never tears mid-frame. Without retrace sync the pending values are taken over on the next clock.

Top module: `hw_cursor_overlay`

## Requirements
- R1: During and after reset `pix_out` and `de_out` are 0, the cursor is disabled, position is (0,0) and retrace sync is off; while the active enable is 0 every pixel passes through unchanged.
- R2: `pix_out` and `de_out` show the pixel and enable presented one clock earlier; a pixel outside the cursor window is passed through unchanged.
- R3: An image entry of 0x0000 leaves the background pixel unchanged.
- R4: An image entry of 0x7FFF replaces the background with its bitwise inverse over all 15 bits.
- R5: An image entry with bit 15 set replaces the background with entry bits 14:0 (0xFFFF gives 0x7FFF, 0x8000 gives 0x0000).
- R6: Any other entry with bit 15 clear is treated as transparent.
- R7: Image RAM address `row*32 + col` (row in address bits 9:5, column in bits 4:0) is drawn at raster (x0+col, y0+row), where (x0,y0) is the active position.
- R8: The position word carries x in bits 11:0 and y in bits 27:16; all other bits are ignored.
- R9: Control bit 0 is the cursor enable and bit 1 selects retrace sync. With sync on, the active position and enable change only in a cycle where `vblank` is high; with sync off they follow the pending values one clock after the write.
- R10: The cursor is drawn only where `de` is high and the raster lies inside the window; the window never wraps past the largest coordinate back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| img_we | input | 1 | Image RAM write strobe |
| img_addr | input | 10 | Image RAM address, row in 9:5, column in 4:0 |
| img_data | input | 16 | Image entry |
| pos_we | input | 1 | Position word write strobe |
| pos_data | input | 32 | Position word, x in 11:0, y in 27:16 |
| ctl_we | input | 1 | Control word write strobe |
| ctl_data | input | 2 | Bit 0 enable, bit 1 retrace sync |
| vblank | input | 1 | Vertical blanking indicator |
| ras_x | input | 12 | Raster column of the incoming pixel |
| ras_y | input | 12 | Raster row of the incoming pixel |
| de | input | 1 | Display enable of the incoming pixel |
| pix_in | input | 15 | Background pixel, RGB555 |
| pix_out | output | 15 | Output pixel, RGB555 |
| de_out | output | 1 | Display enable, delayed to match pix_out |

## Verification
On every cycle the assertions check that the active position and enable hold still under retrace sync outside vertical blanking, that blanked pixels and pixels seen while the cursor is disabled come out unchanged one clock later, and that the enable is delayed by exactly one clock. Only the bench scenarios can show the decoding of the four entry kinds, the row/column placement of the image, the bit packing of the position word, the edge clipping without wrap-around and the exact moment a deferred update becomes visible.

// File: rtl/hw_cursor_overlay.sv
module hw_cursor_overlay #(
  parameter int CW     = 12,
  parameter int SZ_LOG = 5,
  parameter int PIX_W  = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  img_we,
  input  logic [2*SZ_LOG-1:0]   img_addr,
  input  logic [PIX_W:0]        img_data,
  input  logic                  pos_we,
  input  logic [31:0]           pos_data,
  input  logic                  ctl_we,
  input  logic [1:0]            ctl_data,
  input  logic                  vblank,
  input  logic [CW-1:0]         ras_x,
  input  logic [CW-1:0]         ras_y,
  input  logic                  de,
  input  logic [PIX_W-1:0]      pix_in,
  output logic [PIX_W-1:0]      pix_out,
  output logic                  de_out
);
  localparam int DEPTH = 1 << (2*SZ_LOG);
  localparam logic [PIX_W:0] INV_CODE = {1'b0, {PIX_W{1'b1}}};

  logic [PIX_W:0]   mem [DEPTH];
  logic [PIX_W:0]   ram_q;
  logic [CW-1:0]    pend_x, pend_y, act_x, act_y;
  logic             pend_en, act_en, sync_q;
  logic             hit_q;
  logic [PIX_W-1:0] pix_q;

  logic [CW:0] dx, dy;
  logic        hit;
  assign dx  = {1'b0, ras_x} - {1'b0, act_x};
  assign dy  = {1'b0, ras_y} - {1'b0, act_y};
  assign hit = de && act_en && (dx[CW:SZ_LOG] == '0) && (dy[CW:SZ_LOG] == '0);

  always_ff @(posedge clk) begin
    if (img_we) mem[img_addr] <= img_data;
    ram_q <= mem[{dy[SZ_LOG-1:0], dx[SZ_LOG-1:0]}];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_x <= '0; pend_y <= '0; pend_en <= 1'b0; sync_q <= 1'b0;
      act_x  <= '0; act_y  <= '0; act_en  <= 1'b0;
      hit_q  <= 1'b0; pix_q <= '0; de_out <= 1'b0;
    end else begin
      if (pos_we) begin
        pend_x <= pos_data[CW-1:0];
        pend_y <= pos_data[16+CW-1:16];
      end
      if (ctl_we) begin
        pend_en <= ctl_data[0];
        sync_q  <= ctl_data[1];
      end
      if (!sync_q || vblank) begin
        act_x  <= pend_x;
        act_y  <= pend_y;
        act_en <= pend_en;
      end
      hit_q  <= hit;
      pix_q  <= pix_in;
      de_out <= de;
    end
  end

  always_comb begin
    pix_out = pix_q;
    if (hit_q) begin
      if (ram_q[PIX_W])         pix_out = ram_q[PIX_W-1:0];
      else if (ram_q == INV_CODE) pix_out = ~pix_q;
    end
  end

  a_r9_hold_outside_vblank: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && !vblank) |=> ($stable(act_x) && $stable(act_y) && $stable(act_en)));

  a_r10_blank_passes: assert property (@(posedge clk) disable iff (!rst_n)
    !de |=> (pix_out == $past(pix_in)));

  a_r1_disabled_passes: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |=> (pix_out == $past(pix_in)));

  a_r2_de_delay_hi: assert property (@(posedge clk) disable iff (!rst_n)
    de |=> de_out);

  a_r2_de_delay_lo: assert property (@(posedge clk) disable iff (!rst_n)
    !de |=> !de_out);
endmodule

// File: tb/tb_hw_cursor_overlay.sv
module tb_hw_cursor_overlay;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        img_we = 1'b0;
  logic [9:0]  img_addr = '0;
  logic [15:0] img_data = '0;
  logic        pos_we = 1'b0;
  logic [31:0] pos_data = '0;
  logic        ctl_we = 1'b0;
  logic [1:0]  ctl_data = '0;
  logic        vblank = 1'b0;
  logic [11:0] ras_x = '0, ras_y = '0;
  logic        de = 1'b0;
  logic [14:0] pix_in = '0;
  logic [14:0] pix_out;
  logic        de_out;

  int tests = 0, fails = 0;
  logic [15:0] img [1024];
  int m_x = 0, m_y = 0;
  bit m_en = 0;

  always #2.5 clk = ~clk;

  hw_cursor_overlay dut (
    .clk(clk), .rst_n(rst_n), .img_we(img_we), .img_addr(img_addr), .img_data(img_data),
    .pos_we(pos_we), .pos_data(pos_data), .ctl_we(ctl_we), .ctl_data(ctl_data),
    .vblank(vblank), .ras_x(ras_x), .ras_y(ras_y), .de(de), .pix_in(pix_in),
    .pix_out(pix_out), .de_out(de_out));

  function automatic logic [14:0] exp_pix(int x, int y, bit d, logic [14:0] bg);
    int dx = x - m_x;
    int dy = y - m_y;
    logic [15:0] e;
    if (!d || !m_en || dx < 0 || dx > 31 || dy < 0 || dy > 31) return bg;
    e = img[dy*32 + dx];
    if (e[15]) return e[14:0];
    if (e == 16'h7FFF) return ~bg;
    return bg;
  endfunction

  task automatic check(string req, logic [14:0] act, logic [14:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pix(string req, int x, int y, bit d, logic [14:0] bg);
    logic [14:0] e;
    ras_x = x[11:0]; ras_y = y[11:0]; de = d; pix_in = bg;
    e = exp_pix(x, y, d, bg);
    @(negedge clk);
    check(req, pix_out, e);
    check(req, {14'd0, de_out}, {14'd0, d});
  endtask

  task automatic wr_img(int a, logic [15:0] v);
    img[a] = v;
    img_we = 1'b1; img_addr = a[9:0]; img_data = v;
    @(negedge clk);
    img_we = 1'b0;
  endtask

  task automatic wr_pos(logic [31:0] v);
    pos_we = 1'b1; pos_data = v;
    @(negedge clk);
    pos_we = 1'b0;
  endtask

  task automatic wr_ctl(logic [1:0] v);
    ctl_we = 1'b1; ctl_data = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic pulse_vblank;
    vblank = 1'b1;
    @(negedge clk);
    vblank = 1'b0;
  endtask

  initial begin
    #1000000;
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    pix_in = 15'h2AAA; de = 1'b1;
    idle(3);
    check("R1", pix_out, 15'h0);
    check("R1", {14'd0, de_out}, 15'h0);
    rst_n = 1'b1;
    @(negedge clk);
    pix("R1", 0, 0, 1, 15'h1357);

    for (int i = 0; i < 1024; i++) begin
      logic [15:0] v;
      case ($urandom % 6)
        0: v = 16'h0000;
        1: v = 16'h7FFF;
        2: v = 16'h8000;
        3: v = 16'hFFFF;
        4: v = {1'b1, 15'($urandom)};
        default: v = {1'b0, 15'($urandom)};
      endcase
      wr_img(i, v);
    end
    wr_img(0, 16'h0000);
    wr_img(1, 16'h7FFF);
    wr_img(2, 16'h8000);
    wr_img(3, 16'hFFFF);
    wr_img(4, 16'h1234);
    wr_img(5, 16'hABCD);
    wr_img(33, 16'hC210);

    pix("R1", 1, 1, 1, 15'h0F0F);

    wr_pos({4'h0, 12'd50, 4'h0, 12'd100});
    wr_ctl(2'b01);
    idle(3);
    m_x = 100; m_y = 50; m_en = 1;

    pix("R3", 100, 50, 1, 15'h1555);
    pix("R4", 101, 50, 1, 15'h1555);
    pix("R5", 102, 50, 1, 15'h1555);
    pix("R5", 103, 50, 1, 15'h1555);
    pix("R6", 104, 50, 1, 15'h1555);
    pix("R5", 105, 50, 1, 15'h0001);
    pix("R7", 101, 51, 1, 15'h7777);
    pix("R2", 99, 50, 1, 15'h3333);
    pix("R2", 132, 50, 1, 15'h3333);
    pix("R2", 100, 82, 1, 15'h3333);
    pix("R10", 101, 50, 0, 15'h1555);

    for (int i = 0; i < 3000; i++)
      pix("R7", 92 + int'($urandom % 48), 42 + int'($urandom % 48),
          ($urandom % 8) != 0, 15'($urandom));

    wr_pos({4'hF, 12'd4090, 4'hF, 12'd4080});
    idle(3);
    m_x = 4080; m_y = 4090;
    pix("R8", 4080, 4090, 1, 15'h0A0A);
    pix("R8", 4081, 4090, 1, 15'h0A0A);
    pix("R10", 4095, 4095, 1, 15'h1111);
    pix("R10", 0, 4090, 1, 15'h2222);
    pix("R10", 5, 4090, 1, 15'h2222);
    pix("R10", 4081, 0, 1, 15'h2222);
    for (int i = 0; i < 400; i++)
      pix("R10", (4070 + int'($urandom % 40)) % 4096, (4080 + int'($urandom % 30)) % 4096,
          1, 15'($urandom));

    wr_ctl(2'b11);
    wr_pos({4'h0, 12'd300, 4'h0, 12'd200});
    idle(4);
    pix("R9", 4081, 4090, 1, 15'h0C0C);
    pix("R9", 201, 300, 1, 15'h0C0C);
    pulse_vblank();
    m_x = 200; m_y = 300;
    idle(1);
    pix("R9", 201, 300, 1, 15'h0C0C);
    pix("R9", 4081, 4090, 1, 15'h0C0C);

    wr_ctl(2'b10);
    idle(3);
    pix("R9", 201, 300, 1, 15'h0D0D);
    pulse_vblank();
    m_en = 0;
    idle(1);
    pix("R9", 201, 300, 1, 15'h0D0D);
    pix("R1", 202, 300, 1, 15'h0D0D);

    wr_ctl(2'b01);
    idle(3);
    m_en = 1;
    pix("R9", 201, 300, 1, 15'h0E0E);
    pix("R9", 203, 300, 1, 15'h0E0E);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule